// File: doc/BRIEF.md
# Four-Slice 10-bit PWM Generator

This block turns a 10-bit duty value into a pulse-width-modulated output bit. Each conversion period is split into four equal slices, and each slice begins with a high pulse. The programmed high time is shared out evenly over the four slices. The slices that come first in the period take the remainder ticks. Spreading the high time this way pushes the ripple frequency up by four. A plain RC filter then gives a smoother analogue level.

Software sets the duty value in two byte writes, lower byte first and upper byte second. The upper-byte write moves the complete 10-bit value into a holding register. A separate control write picks the tick rate and sets the output-enable bit. A new value or tick rate reaches the waveform only at the next period boundary, so a period in progress always runs to its end. A conversion period is always 1024 ticks. The 2-bit select sets how many system clocks one period takes.

Top module: `pdiv_pwm`

## Requirements
- R1: After reset the output is low, the duty value is 0, the select code is 00 and the output is disabled.
- R2: A cycle with `wr_ctl` high loads the select code from `wr_data[1:0]` and the enable bit from `wr_data[2]`. Select codes 00, 01, 10 and 11 give a period of 512, 1024, 2048 and 4096 clocks.
- R3: For select codes 01, 10 and 11 one tick is 1, 2 or 4 clocks. Over one period the output is high for (data+4) ticks, saturating at the full period.
- R4: Select code 00 runs with a half-clock tick that is resolved two ticks per clock. A slice that is high for H ticks is then high for ceil(H/2) clocks.
- R5: Each period has four slices of 256 ticks, and each slice starts high. Slice i (i = 0 to 3) is high for floor(data/4)+1 ticks, plus one tick when i < data mod 4, capped at 256.
- R6: A lower-byte write (`wr_lo`) on its own changes neither the output nor the held duty value.
- R7: An upper-byte write (`wr_hi`) moves {`wr_data[1:0]`, last lower byte} into the holding register as one 10-bit value. The upper byte holds data bits 9:8 and the lower byte holds bits 7:0.
- R8: A new duty value or select code takes effect only at the next period boundary. The waveform of the period in progress does not change.
- R9: While the enable bit is clear the output is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_lo | input | 1 | Write strobe for the lower duty byte |
| wr_hi | input | 1 | Write strobe for the upper duty bits; commits the full value |
| wr_ctl | input | 1 | Write strobe for the select code and enable bit |
| wr_data | input | 8 | Write data shared by the three strobes |
| pwm_out | output | 1 | PWM waveform |

## Verification
A wrong period counter or prescaler changes the number of high clocks counted over one period. This shows in the first full period after the fault, within 4096 clocks. A transfer made at the wrong time shows as a wrong level at one known clock just before or just after a boundary. A lower-byte write that reaches the live value shifts the measured high total within one period. A faulty enable gate shows as a nonzero total on a disabled output.

// File: rtl/pdiv_pwm.sv
module pdiv_pwm #(
  parameter int DW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic       wr_ctl,
  input  logic [7:0] wr_data,
  output logic       pwm_out
);
  localparam int SW = DW - 2;
  localparam int UW = DW - 8;

  logic [7:0]    lo_q;
  logic [DW-1:0] hold_q, act_q, cnt_q;
  logic [1:0]    sel_q, asel_q, pre_q, pre_lim;
  logic          oe_q, tick, wrap;
  logic [DW:0]   cnt_sum;
  logic [SW:0]   hi_len;

  always_comb begin
    case (asel_q)
      2'd2:    pre_lim = 2'd1;
      2'd3:    pre_lim = 2'd3;
      default: pre_lim = 2'd0;
    endcase
  end

  assign tick    = (asel_q == 2'd0) || (pre_q == pre_lim);
  assign cnt_sum = {1'b0, cnt_q} + ((asel_q == 2'd0) ? (DW+1)'(2) : (DW+1)'(1));
  assign wrap    = tick && cnt_sum[DW];

  assign hi_len  = {1'b0, act_q[DW-1:2]} + (SW+1)'(1)
                 + (SW+1)'(cnt_q[DW-1:SW] < act_q[1:0]);
  assign pwm_out = oe_q && ({1'b0, cnt_q[SW-1:0]} < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hold_q <= '0;
      sel_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (wr_lo)  lo_q   <= wr_data;
      if (wr_hi)  hold_q <= {wr_data[UW-1:0], lo_q};
      if (wr_ctl) begin
        sel_q <= wr_data[1:0];
        oe_q  <= wr_data[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      act_q  <= '0;
      asel_q <= '0;
    end else begin
      pre_q <= tick ? 2'd0 : pre_q + 2'd1;
      if (tick) cnt_q <= cnt_sum[DW-1:0];
      if (wrap) begin
        act_q  <= hold_q;
        asel_q <= sel_q;
      end
    end
  end
endmodule

// File: rtl/pdiv_pwm_chk.sv
module pdiv_pwm_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic [7:0]    wr_data,
  input logic          pwm_out,
  input logic          oe_q,
  input logic [7:0]    lo_q,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] hold_q,
  input logic [DW-1:0] act_q,
  input logic [1:0]    asel_q
);
  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !pwm_out);

  // R5
  slice_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && cnt_q[DW-3:0] == '0) |-> pwm_out);

  // R8
  mid_period_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(act_q));

  // R8
  mid_period_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(asel_q));

  // R6
  lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(hold_q));

  // R7
  hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (hold_q == {$past(wr_data[DW-9:0]), $past(lo_q)}));
endmodule

bind pdiv_pwm pdiv_pwm_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
  .pwm_out(pwm_out), .oe_q(oe_q), .lo_q(lo_q), .cnt_q(cnt_q),
  .hold_q(hold_q), .act_q(act_q), .asel_q(asel_q)
);

// File: tb/pdiv_pwm_tb.sv
`timescale 1ns/1ps
module pdiv_pwm_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_lo = 1'b0, wr_hi = 1'b0, wr_ctl = 1'b0;
  logic [7:0] wr_data = '0;
  logic pwm_out;
  int k = 0, n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) k <= rst_n ? k + 1 : 0;

  pdiv_pwm u_dut (.clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
                  .wr_ctl(wr_ctl), .wr_data(wr_data), .pwm_out(pwm_out));

  // {oe, sel[1:0], data[9:0], expected high clocks per period[12:0]}
  localparam logic [25:0] VEC [8] = '{
    {1'b1, 2'd1, 10'd0,    13'd4},     // R3 minimum
    {1'b1, 2'd1, 10'd513,  13'd517},   // R3 R5 remainder in slice 0
    {1'b1, 2'd2, 10'd100,  13'd208},   // R3
    {1'b1, 2'd3, 10'd7,    13'd44},    // R3 R5
    {1'b1, 2'd0, 10'd5,    13'd5},     // R4 slices 3,2,2,2 ticks
    {1'b1, 2'd0, 10'd1020, 13'd512},   // R4 full
    {1'b1, 2'd2, 10'd1023, 13'd2048},  // R3 R5 saturation
    {1'b0, 2'd3, 10'd300,  13'd0}      // R9
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int which, logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_lo = (which == 0); wr_hi = (which == 1); wr_ctl = (which == 2);
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0; wr_ctl = 1'b0;
  endtask

  task automatic load(logic oe, logic [1:0] sel, logic [9:0] d);
    wr(0, d[7:0]);
    wr(1, {6'b0, d[9:8]});
    wr(2, {5'b0, oe, sel});
  endtask

  task automatic measure(logic [1:0] sel, output int hc);
    int per;
    per = (sel == 2'd0) ? 512 : (1024 << (sel - 1));
    repeat (4100) @(negedge clk);
    hc = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      hc += pwm_out;
    end
  endtask

  task automatic go_to(int n);
    while (k != n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int hc;
    repeat (3) @(negedge clk);
    chk("R1 out during reset", pwm_out, 0);
    rst_n = 1'b1;
    measure(2'd0, hc);
    chk("R1 disabled after reset", hc, 0);

    for (int v = 0; v < 8; v++) begin
      load(VEC[v][25], VEC[v][24:23], VEC[v][22:13]);
      measure(VEC[v][24:23], hc);
      chk($sformatf("R2 R3 R4 vector %0d", v), hc, int'(VEC[v][12:0]));
    end

    load(1'b1, 2'd1, 10'h110);
    measure(2'd1, hc);
    chk("R7 two-byte value", hc, 276);
    wr(0, 8'hFF);
    measure(2'd1, hc);
    chk("R6 lower byte alone", hc, 276);
    wr(1, 8'h00);
    measure(2'd1, hc);
    chk("R7 upper write commits lower", hc, 259);

    do_reset();
    go_to(10);
    wr(2, 8'h05);
    go_to(512);
    chk("R5 slice start", pwm_out, 1);
    go_to(513);
    chk("R3 one tick high at data 0", pwm_out, 0);
    go_to(700);
    wr(0, 8'hFC);
    wr(1, 8'h03);
    go_to(1000);
    chk("R8 mid-period hold", pwm_out, 0);
    go_to(1535);
    chk("R8 last clock of old period", pwm_out, 0);
    go_to(1536);
    chk("R8 boundary applies", pwm_out, 1);
    go_to(1700);
    chk("R8 new value in force", pwm_out, 1);
    wr(2, 8'h01);
    @(negedge clk);
    chk("R9 disable drives low", pwm_out, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule